// File: doc/BRIEF.md
# Interrupt Source-ID Validator

This block decides whether an incoming interrupt request may use the table entry it selects. Its inputs are the 16-bit requester ID and the three validation fields of that entry: a validation type, a qualifier and a source-ID. It returns a pass or fail verdict. The entry is fetched upstream. Fault reporting and interrupt delivery happen downstream.

All decoding and comparison is combinational. The verdict is registered, and a valid strobe marks it one clock after the request. A global check-disable input overrides the entry's type so that every request passes.

Requester ID and source-ID both place the bus number in bits 15:8 and device/function in bits 7:0.

Top module: `srcid_validator`

## Requirements
- R1: While rst_n is low at a clock edge, vrd_valid and vrd_pass are both 0 after that edge.
- R2: A request sampled with req_valid high at a rising edge produces vrd_valid high for exactly the following cycle. A cycle with req_valid low produces vrd_valid low in the following cycle, so back-to-back requests give back-to-back strobes.
- R3: Validation type 0 (no check) passes every request, whatever the requester ID, qualifier and source-ID are.
- R4: In validation type 1 (ID match), qualifier 0 passes only when all 16 bits of the requester ID equal the source-ID.
- R5: In type 1, qualifier 1 leaves bit 2 out of the comparison and compares every other bit.
- R6: In type 1, qualifier 2 leaves bits 2 and 1 out of the comparison.
- R7: In type 1, qualifier 3 leaves bits 2, 1 and 0 out of the comparison. Under every qualifier, bits 15:3 are always compared.
- R8: In validation type 2 (bus range), the source-ID holds a first bus in bits 15:8 and a last bus in bits 7:0. The request passes only when requester bits 15:8 lie between them, inclusive. Requester bits 7:0 and the qualifier are ignored, and a first bus above the last bus passes nothing.
- R9: Validation type 3 is reserved and always fails.
- R10: With chk_disable high at the request, the type is treated as 0 and the request passes.
- R11: vrd_pass keeps its last verdict in cycles that carry no new verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_rid | input | 16 | Requester ID (bus 15:8, device/function 7:0) |
| ent_vtype | input | 2 | Entry validation type (0 none, 1 ID match, 2 bus range, 3 reserved) |
| ent_qual | input | 2 | Entry qualifier: how many low ID bits to ignore in type 1 |
| ent_sid | input | 16 | Entry source-ID, or first/last bus in type 2 |
| chk_disable | input | 1 | Global override: treat every entry as type 0 |
| vrd_valid | output | 1 | Verdict strobe, one cycle after a request |
| vrd_pass | output | 1 | Verdict: 1 pass, 0 fail |

## Verification
Each qualifier is tested in two ways. First, the requester ID differs from the source-ID only in the bits that qualifier may ignore. Second, it differs in the next bit that must still be compared. A mask shifted by one bit, or one that reads the qualifier the wrong way round, passes the second case or fails the first. Bus-range requests sit exactly on the first and last bus, one bus outside each end, and in an inverted range, which catches exclusive bounds, swapped fields and a device/function byte that leaks into the comparison. The reserved type, the disable override of both the reserved type and a mismatching entry, back-to-back requests, and the cycle after each verdict all have their own checks. These catch a reserved type that passes, an override that is ignored, a strobe that lasts too long or merges two requests, and a verdict that drops back to 0 between requests.

// File: rtl/sidv_pkg.sv
// Package: shared types and sizes for the source-ID validator.
// Assumes a requester ID made of a bus byte above a device/function byte.
package sidv_pkg;
    localparam int RID_W  = 16;
    localparam int VT_W   = 2;
    localparam int QUAL_W = 2;

    typedef enum logic [VT_W-1:0] {
        VT_NONE     = 2'd0,
        VT_IDMATCH  = 2'd1,
        VT_BUSRANGE = 2'd2,
        VT_RSVD     = 2'd3
    } vtype_e;
endpackage

// File: rtl/sidv_qual_mask.sv
// Module: builds the compare mask for ID-match mode from the qualifier.
// A low bit i (i < IGN_BITS) is dropped when qual >= IGN_BITS - i, so a larger
// qualifier drops more bits, counted down from the top of the low group.
// Assumes the qualifier can count up to IGN_BITS.
module sidv_qual_mask #(
    parameter int ID_W     = 16,
    parameter int QUAL_W   = 2,
    parameter int IGN_BITS = 3
) (
    input  logic [QUAL_W-1:0] qual,
    output logic [ID_W-1:0]   care
);
    // One generate branch per mask bit: bits in the low group depend on qual.
    for (genvar i = 0; i < ID_W; i++) begin : g_bit
        if (i < IGN_BITS) begin : g_low
            assign care[i] = (qual < QUAL_W'(IGN_BITS - i));
        end else begin : g_high
            assign care[i] = 1'b1;
        end
    end
endmodule

// File: rtl/sidv_id_match.sv
// Module: masked equality between requester ID and entry source-ID.
// Assumes care has a 1 for every bit that takes part in the comparison.
module sidv_id_match #(
    parameter int ID_W = 16
) (
    input  logic [ID_W-1:0] rid,
    input  logic [ID_W-1:0] sid,
    input  logic [ID_W-1:0] care,
    output logic            hit
);
    logic [ID_W-1:0] diff;

    // Mark differing bits that are not masked, then test that none remain.
    always_comb begin
        diff = (rid ^ sid) & care;
        hit  = (diff == '0);
    end
endmodule

// File: rtl/sidv_bus_range.sv
// Module: inclusive bus-range test for bus-range mode.
// The upper half of the source-ID is the first bus and the lower half is the
// last bus. An inverted range matches nothing. Assumes ID_W is even.
module sidv_bus_range #(
    parameter int ID_W = 16
) (
    input  logic [ID_W-1:0] rid,
    input  logic [ID_W-1:0] sid,
    output logic            hit
);
    localparam int BUS_W = ID_W / 2;

    logic [BUS_W-1:0] bus;
    logic [BUS_W-1:0] first_bus;
    logic [BUS_W-1:0] last_bus;

    // Split the fields and test both bounds, each inclusive.
    always_comb begin
        bus       = rid[ID_W-1:BUS_W];
        first_bus = sid[ID_W-1:BUS_W];
        last_bus  = sid[BUS_W-1:0];
        hit       = (bus >= first_bus) && (bus <= last_bus);
    end
endmodule

// File: rtl/srcid_validator.sv
// Module: top of the source-ID validator. Works out the effective validation
// type (forced to none by chk_disable), selects the sub-check and registers
// the verdict with a one-cycle strobe. The verdict holds between requests.
// Assumes the inputs are stable at the edge where req_valid is high.
module srcid_validator
    import sidv_pkg::*;
#(
    parameter int IGN_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [VT_W-1:0]   ent_vtype,
    input  logic [QUAL_W-1:0] ent_qual,
    input  logic [RID_W-1:0]  ent_sid,
    input  logic              chk_disable,
    output logic              vrd_valid,
    output logic              vrd_pass
);
    logic [RID_W-1:0] care;
    logic             id_hit;
    logic             bus_hit;
    vtype_e           eff_type;
    logic             pass_now;

    sidv_qual_mask #(.ID_W(RID_W), .QUAL_W(QUAL_W), .IGN_BITS(IGN_BITS)) u_mask (
        .qual (ent_qual),
        .care (care)
    );

    sidv_id_match #(.ID_W(RID_W)) u_idm (
        .rid  (req_rid),
        .sid  (ent_sid),
        .care (care),
        .hit  (id_hit)
    );

    sidv_bus_range #(.ID_W(RID_W)) u_bus (
        .rid (req_rid),
        .sid (ent_sid),
        .hit (bus_hit)
    );

    // Pick the effective type, then the verdict that type calls for.
    always_comb begin
        eff_type = chk_disable ? VT_NONE : vtype_e'(ent_vtype);
        unique case (eff_type)
            VT_NONE:     pass_now = 1'b1;
            VT_IDMATCH:  pass_now = id_hit;
            VT_BUSRANGE: pass_now = bus_hit;
            default:     pass_now = 1'b0;
        endcase
    end

    // Register the strobe every cycle; load the verdict only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vrd_valid <= 1'b0;
            vrd_pass  <= 1'b0;
        end else begin
            vrd_valid <= req_valid;
            if (req_valid) begin
                vrd_pass <= pass_now;
            end
        end
    end
endmodule

// File: rtl/srcid_validator_chk.sv
// Module: assertion checker for srcid_validator, attached with bind.
// Relates the request ports to the registered verdict one cycle later.
module srcid_validator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] ent_vtype,
    input logic       chk_disable,
    input logic       vrd_valid,
    input logic       vrd_pass
);
    // R2
    strobe_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> vrd_valid);
    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !vrd_valid);
    // R3
    type_none_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !chk_disable && ent_vtype == 2'd0) |=> vrd_pass);
    // R9
    type_rsvd_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !chk_disable && ent_vtype == 2'd3) |=> !vrd_pass);
    // R10
    disable_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_disable) |=> vrd_pass);
    // R11
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(vrd_pass));
endmodule

bind srcid_validator srcid_validator_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .ent_vtype   (ent_vtype),
    .chk_disable (chk_disable),
    .vrd_valid   (vrd_valid),
    .vrd_pass    (vrd_pass)
);

// File: tb/srcid_validator_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, with expected verdicts taken from
// the requirements.
module srcid_validator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_rid = '0;
    logic [1:0]  ent_vtype = '0;
    logic [1:0]  ent_qual = '0;
    logic [15:0] ent_sid = '0;
    logic        chk_disable = 1'b0;
    logic        vrd_valid;
    logic        vrd_pass;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    srcid_validator u_srcid_validator (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rid(req_rid),
        .ent_vtype(ent_vtype), .ent_qual(ent_qual), .ent_sid(ent_sid),
        .chk_disable(chk_disable), .vrd_valid(vrd_valid), .vrd_pass(vrd_pass)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One request, then its verdict cycle, then the idle cycle that follows.
    task automatic one_req(input string tag, input logic [15:0] rid,
                           input logic [1:0] vt, input logic [1:0] q,
                           input logic [15:0] sid, input logic dis,
                           input logic exp);
        @(negedge clk);
        req_rid = rid; ent_vtype = vt; ent_qual = q; ent_sid = sid;
        chk_disable = dis; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R2 strobe"}, vrd_valid, 1'b1);
        check({tag, " verdict"}, vrd_pass, exp);
        req_rid = ~rid; ent_vtype = 2'd3; chk_disable = 1'b0;
        @(negedge clk);
        check({tag, " R2 strobe ends"}, vrd_valid, 1'b0);
        check({tag, " R11 hold"}, vrd_pass, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", vrd_valid, 1'b0);
        check("R1 pass in reset", vrd_pass, 1'b0);
        req_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_none();
        one_req("R3 type0 any id", 16'habcd, 2'd0, 2'd3, 16'h0000, 1'b0, 1'b1);
    endtask

    task automatic t_full();
        one_req("R4 q0 equal", 16'h1234, 2'd1, 2'd0, 16'h1234, 1'b0, 1'b1);
        one_req("R4 q0 bit0 diff", 16'h1235, 2'd1, 2'd0, 16'h1234, 1'b0, 1'b0);
    endtask

    task automatic t_q1();
        one_req("R5 q1 bit2 ignored", 16'h1234, 2'd1, 2'd1, 16'h1230, 1'b0, 1'b1);
        one_req("R5 q1 bit1 compared", 16'h1232, 2'd1, 2'd1, 16'h1230, 1'b0, 1'b0);
    endtask

    task automatic t_q2();
        one_req("R6 q2 bits2-1 ignored", 16'h1236, 2'd1, 2'd2, 16'h1230, 1'b0, 1'b1);
        one_req("R6 q2 bit0 compared", 16'h1231, 2'd1, 2'd2, 16'h1230, 1'b0, 1'b0);
    endtask

    task automatic t_q3();
        one_req("R7 q3 low3 ignored", 16'h1237, 2'd1, 2'd3, 16'h1230, 1'b0, 1'b1);
        one_req("R7 q3 bit3 compared", 16'h1238, 2'd1, 2'd3, 16'h1230, 1'b0, 1'b0);
        one_req("R7 q3 bus compared", 16'h1337, 2'd1, 2'd3, 16'h1230, 1'b0, 1'b0);
    endtask

    task automatic t_bus();
        one_req("R8 first bus", 16'h10ff, 2'd2, 2'd0, 16'h1020, 1'b0, 1'b1);
        one_req("R8 last bus", 16'h2000, 2'd2, 2'd0, 16'h1020, 1'b0, 1'b1);
        one_req("R8 inside", 16'h1855, 2'd2, 2'd3, 16'h1020, 1'b0, 1'b1);
        one_req("R8 below first", 16'h0fff, 2'd2, 2'd0, 16'h1020, 1'b0, 1'b0);
        one_req("R8 above last", 16'h2100, 2'd2, 2'd0, 16'h1020, 1'b0, 1'b0);
        one_req("R8 inverted range", 16'h1800, 2'd2, 2'd0, 16'h2010, 1'b0, 1'b0);
    endtask

    task automatic t_rsvd();
        one_req("R9 reserved", 16'h1234, 2'd3, 2'd0, 16'h1234, 1'b0, 1'b0);
    endtask

    task automatic t_disable();
        one_req("R10 disable rsvd", 16'h1234, 2'd3, 2'd0, 16'h1234, 1'b1, 1'b1);
        one_req("R10 disable mismatch", 16'h5678, 2'd1, 2'd0, 16'h1234, 1'b1, 1'b1);
    endtask

    task automatic t_back2back();
        @(negedge clk);
        req_rid = 16'h1234; ent_vtype = 2'd1; ent_qual = 2'd0;
        ent_sid = 16'h1234; chk_disable = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        check("R2 b2b first strobe", vrd_valid, 1'b1);
        check("R2 b2b first verdict", vrd_pass, 1'b1);
        req_rid = 16'h4321;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 b2b second strobe", vrd_valid, 1'b1);
        check("R2 b2b second verdict", vrd_pass, 1'b0);
        @(negedge clk);
        check("R2 b2b strobe ends", vrd_valid, 1'b0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        t_reset();
        t_none();
        t_full();
        t_q1();
        t_q2();
        t_q3();
        t_bus();
        t_rsvd();
        t_disable();
        t_back2back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule